// File: doc/BRIEF.md
# Multi-code symbol spreading encoder

This block is the spreading half of a direct-sequence transmitter. Message bits arrive one at a time and are gathered into packets of one, two or three bits. Each finished packet is then replaced by a whole 11-chip spreading code taken from a bank of 2, 4 or 8 codes. The packet value picks the code. The chips of that code leave serially in polar form (+1 / -1), ready to drive a BPSK multiplier. A carrier stage would never see a single fixed sequence: which code appears depends on the data. If the bank holds mutually uncorrelated codes, an observer without the bank cannot tell which code carries a packet.

The bit input is a valid/ready stream. A bit transfers on a clock edge where `bit_valid_i` and `bit_ready_o` are both high. Ready is high while a packet is being collected and drops for the 11 cycles in which that packet's chips are sent, so the upstream source is held off. Bits offered while ready is low are not taken and must be held or offered again. The chip output has no back-pressure: once a packet is complete, its 11 chips leave on consecutive cycles. The bank is written through a simple load port. The bits-per-packet setting is a plain static input that is read at the start of each packet.

Top module: `mcs_encoder`

## Requirements
- R1: After reset `bit_ready_o` is 1, and `chip_valid_o` and `sym_start_o` are 0. `chip_o` is 0 whenever `chip_valid_o` is 0.
- R2: `mode_i` gives the bits per packet: 1 gives 1 bit (2 codes), 2 gives 2 bits (4 codes), 3 gives 3 bits (8 codes), and 0 behaves as 1.
- R3: The first bit of a packet to arrive becomes its most significant bit. The packet value, read as an unsigned number, is the index of the bank entry sent, so value 0 selects entry 0.
- R4: The chips of the selected 11-bit code appear bit 10 first and bit 0 last. There is one chip per cycle on 11 consecutive cycles, and the first chip appears in the cycle after the edge that accepted the packet's last bit.
- R5: A chip bit of 1 is output as +1 (2'b01) and a chip bit of 0 as -1 (2'b11), as a 2-bit signed value.
- R6: `sym_start_o` is high with the first chip of each code and low for all other chips.
- R7: `bit_ready_o` is 0 during the 11 chip cycles and 1 at all other times out of reset. Bits offered while it is 0 are not taken and do not change any later packet.
- R8: The packet length is fixed by `mode_i` at the edge that accepts the packet's first bit. A mode change later in the packet has no effect until the next packet.
- R9: A write with `load_en_i` stores `load_code_i` into entry `load_idx_i`, and packets completed after that edge use it. The code of a packet is captured when its last bit is accepted, so a write during its chips leaves those chips unchanged.
- R10: After reset, entry i of the bank holds the base code 11'b11100010010 rotated left by i positions.
- R11: Reset discards a partly collected packet: the first bit accepted after reset starts a new packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Bits per packet (0 or 1: one bit, 2: two bits, 3: three bits) |
| bit_valid_i | input | 1 | Message bit offered |
| bit_data_i | input | 1 | Message bit value |
| bit_ready_o | output | 1 | Encoder can accept a message bit |
| load_en_i | input | 1 | Write one bank entry |
| load_idx_i | input | 3 | Bank entry to write |
| load_code_i | input | 11 | Code to store, bit 10 sent first |
| chip_valid_o | output | 1 | A chip is present on `chip_o` |
| chip_o | output | 2 | Polar chip, signed: +1 or -1, 0 when idle |
| sym_start_o | output | 1 | First chip of a code |

## Verification
The assertions check several properties on every cycle:
- chips arrive in unbroken runs of exactly 11;
- every run opens with the start strobe;
- a chip is always +1 or -1;
- a completed packet always lowers ready on the next cycle;
- a bank write lands in the addressed entry.

Whether the right code comes out for a given packet can only be shown by the bench's scenarios. The same holds for bit order within a packet, when the mode is taken, that bits are ignored under back-pressure, that a code is captured before a bank write, and that a partial packet is discarded at reset. To cover these, the bench sweeps every packet value in every mode, first over the reset bank and then over a loaded bank.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef logic signed [1:0] polar_t;

  localparam polar_t POLAR_POS  = 2'sb01;
  localparam polar_t POLAR_NEG  = 2'sb11;
  localparam polar_t POLAR_IDLE = 2'sb00;

  function automatic polar_t to_polar(input logic chip);
    return chip ? POLAR_POS : POLAR_NEG;
  endfunction
endpackage

// File: rtl/mcs_collect.sv
module mcs_collect #(
  parameter int MAX_BITS = 3,
  localparam int CW = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CW-1:0]       mode_i,
  input  logic                bit_valid_i,
  input  logic                bit_data_i,
  input  logic                busy_i,
  output logic                ready_o,
  output logic                done_o,
  output logic [MAX_BITS-1:0] idx_o
);
  logic [MAX_BITS-1:0] shreg;
  logic [CW-1:0]       cnt;
  logic [CW-1:0]       need_q;
  logic [CW-1:0]       need_now;
  logic [MAX_BITS-1:0] shift_next;
  logic                take;

  function automatic logic [CW-1:0] bits_for(input logic [CW-1:0] m);
    if (m == '0) return CW'(1);
    if (m > CW'(MAX_BITS)) return CW'(MAX_BITS);
    return m;
  endfunction

  assign ready_o    = !busy_i;
  assign take       = bit_valid_i && ready_o;
  assign need_now   = (cnt == '0) ? bits_for(mode_i) : need_q;
  assign shift_next = (shreg << 1) | MAX_BITS'(bit_data_i);
  assign done_o     = take && ((cnt + CW'(1)) == need_now);
  assign idx_o      = shift_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      cnt    <= '0;
      need_q <= CW'(1);
    end else if (take) begin
      if (cnt == '0) need_q <= need_now;
      if (done_o) begin
        cnt   <= '0;
        shreg <= '0;
      end else begin
        cnt   <= cnt + CW'(1);
        shreg <= shift_next;
      end
    end
  end

  // R7: a finished packet always starts the chip run on the next cycle
  assert_busy_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> busy_i);
  // R8: the latched length is never below the bits already held
  assert_count_in_packet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> (cnt < need_q));
endmodule

// File: rtl/mcs_bank.sv
module mcs_bank #(
  parameter int                CHIPS     = 11,
  parameter int                NCODES    = 8,
  parameter logic [CHIPS-1:0]  BASE_CODE = 11'b11100010010,
  localparam int               AW        = $clog2(NCODES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en_i,
  input  logic [AW-1:0]    load_idx_i,
  input  logic [CHIPS-1:0] load_code_i,
  input  logic [AW-1:0]    rd_idx_i,
  output logic [CHIPS-1:0] rd_code_o
);
  logic [CHIPS-1:0] mem [NCODES];

  function automatic logic [CHIPS-1:0] rotl(input logic [CHIPS-1:0] b, input int r);
    logic [CHIPS-1:0] v;
    v = b;
    for (int k = 0; k < r % CHIPS; k++) v = {v[CHIPS-2:0], v[CHIPS-1]};
    return v;
  endfunction

  for (genvar i = 0; i < NCODES; i++) begin : g_entry
    localparam logic [CHIPS-1:0] INIT = rotl(BASE_CODE, i);
    always_ff @(posedge clk) begin
      if (!rst_n)                                  mem[i] <= INIT;
      else if (load_en_i && load_idx_i == AW'(i))  mem[i] <= load_code_i;
    end
    // R9: a write lands in the addressed entry
    assert_load_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en_i && load_idx_i == AW'(i)) |=> (mem[i] == $past(load_code_i)));
  end

  assign rd_code_o = mem[rd_idx_i];
endmodule

// File: rtl/mcs_serial.sv
module mcs_serial
  import mcs_pkg::*;
#(
  parameter int CHIPS = 11,
  localparam int CW = $clog2(CHIPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CHIPS-1:0] code_i,
  output logic             busy_o,
  output logic             chip_valid_o,
  output polar_t           chip_o,
  output logic             sym_start_o
);
  logic [CHIPS-1:0] sreg;
  logic [CW-1:0]    ccnt;
  logic [CW:0]      run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      sreg   <= '0;
      ccnt   <= '0;
    end else if (busy_o) begin
      sreg <= sreg << 1;
      if (ccnt == CW'(CHIPS - 1)) begin
        busy_o <= 1'b0;
        ccnt   <= '0;
      end else begin
        ccnt <= ccnt + CW'(1);
      end
    end else if (start_i) begin
      busy_o <= 1'b1;
      sreg   <= code_i;
      ccnt   <= '0;
    end
  end

  assign chip_valid_o = busy_o;
  assign sym_start_o  = busy_o && (ccnt == '0);
  assign chip_o       = busy_o ? to_polar(sreg[CHIPS-1]) : POLAR_IDLE;

  // length of the current chip run, for the run-length check
  always_ff @(posedge clk) begin
    if (!rst_n)            run <= '0;
    else if (chip_valid_o) run <= run + (CW+1)'(1);
    else                   run <= '0;
  end

  // R4: a run, once started, has no gaps
  assert_chips_contiguous_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_valid_o && !sym_start_o) |-> $past(chip_valid_o));
  // R4: every run is exactly CHIPS long
  assert_run_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chip_valid_o) |-> (run == (CW+1)'(CHIPS)));
  // R6: a run opens with the strobe
  assert_run_opens_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_valid_o) |-> sym_start_o);
  // R5: chips are only +1 or -1
  assert_polar_values_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chip_valid_o |-> (chip_o == POLAR_POS || chip_o == POLAR_NEG));
endmodule

// File: rtl/mcs_encoder.sv
module mcs_encoder
  import mcs_pkg::*;
#(
  parameter int               MAX_BITS  = 3,
  parameter int               CHIPS     = 11,
  parameter logic [CHIPS-1:0] BASE_CODE = 11'b11100010010
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [$clog2(MAX_BITS+1)-1:0]       mode_i,
  input  logic                                bit_valid_i,
  input  logic                                bit_data_i,
  output logic                                bit_ready_o,
  input  logic                                load_en_i,
  input  logic [MAX_BITS-1:0]                 load_idx_i,
  input  logic [CHIPS-1:0]                    load_code_i,
  output logic                                chip_valid_o,
  output logic signed [1:0]                   chip_o,
  output logic                                sym_start_o
);
  localparam int NCODES = 1 << MAX_BITS;

  logic                busy;
  logic                done;
  logic [MAX_BITS-1:0] idx;
  logic [CHIPS-1:0]    code;

  mcs_collect #(.MAX_BITS(MAX_BITS)) u_collect (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .bit_valid_i(bit_valid_i), .bit_data_i(bit_data_i),
    .busy_i(busy), .ready_o(bit_ready_o), .done_o(done), .idx_o(idx)
  );

  mcs_bank #(.CHIPS(CHIPS), .NCODES(NCODES), .BASE_CODE(BASE_CODE)) u_bank (
    .clk(clk), .rst_n(rst_n), .load_en_i(load_en_i), .load_idx_i(load_idx_i),
    .load_code_i(load_code_i), .rd_idx_i(idx), .rd_code_o(code)
  );

  mcs_serial #(.CHIPS(CHIPS)) u_serial (
    .clk(clk), .rst_n(rst_n), .start_i(done), .code_i(code),
    .busy_o(busy), .chip_valid_o(chip_valid_o), .chip_o(chip_o),
    .sym_start_o(sym_start_o)
  );

  // R7: no bit is taken while chips are leaving
  assert_ready_low_sending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sym_start_o |-> !bit_ready_o);
  // R1: the idle output is zero
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_valid_o |-> (chip_o == 2'sb00 && !sym_start_o));
endmodule

// File: tb/mcs_encoder_test.sv
module mcs_encoder_test;
  localparam int CHIPS = 11;
  localparam logic [10:0] BASE = 11'b11100010010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'd1;
  logic        bit_valid_i = 1'b0;
  logic        bit_data_i = 1'b0;
  logic        bit_ready_o;
  logic        load_en_i = 1'b0;
  logic [2:0]  load_idx_i = '0;
  logic [10:0] load_code_i = '0;
  logic        chip_valid_o;
  logic signed [1:0] chip_o;
  logic        sym_start_o;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  logic [10:0] exp_bank [8];

  mcs_encoder uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .bit_valid_i(bit_valid_i),
    .bit_data_i(bit_data_i), .bit_ready_o(bit_ready_o), .load_en_i(load_en_i),
    .load_idx_i(load_idx_i), .load_code_i(load_code_i),
    .chip_valid_o(chip_valid_o), .chip_o(chip_o), .sym_start_o(sym_start_o)
  );

  always #4 clk = ~clk;

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [10:0] rotl(input logic [10:0] b, input int r);
    logic [10:0] v = b;
    for (int k = 0; k < r; k++) v = {v[9:0], v[10]};
    return v;
  endfunction

  task automatic reset_bank_model();
    for (int i = 0; i < 8; i++) exp_bank[i] = rotl(BASE, i);  // R10
  endtask

  task automatic push_bit(input logic b);
    @(negedge clk);
    while (!bit_ready_o) @(negedge clk);
    bit_valid_i = 1'b1;
    bit_data_i  = b;
    @(negedge clk);
    bit_valid_i = 1'b0;
  endtask

  // entered at the negedge after the accepting edge: first chip is visible
  task automatic check_run(input logic [10:0] code, input bit noise,
                           input bit do_load, input logic [2:0] lidx,
                           input logic [10:0] lcode);
    for (int k = 0; k < CHIPS; k++) begin
      check("R4 chip valid", int'(chip_valid_o), 1);
      check("R5 R3 chip value", int'(chip_o), code[10-k] ? 1 : -1);
      check("R6 strobe", int'(sym_start_o), (k == 0) ? 1 : 0);
      check("R7 ready low", int'(bit_ready_o), 0);
      bit_valid_i = noise && (k < CHIPS - 1);
      bit_data_i  = 1'b1;
      load_en_i   = do_load && (k == 3);
      load_idx_i  = lidx;
      load_code_i = lcode;
      @(negedge clk);
    end
    bit_valid_i = 1'b0;
    load_en_i   = 1'b0;
    if (do_load) exp_bank[lidx] = lcode;
    check("R7 ready back", int'(bit_ready_o), 1);
    check("R1 idle valid", int'(chip_valid_o), 0);
    check("R1 idle chip", int'(chip_o), 0);
  endtask

  task automatic send(input logic [1:0] m, input int nbits, input int val);
    mode_i = m;
    for (int b = nbits - 1; b >= 0; b--) push_bit(val[b]);
    check_run(exp_bank[val], 1'b0, 1'b0, 3'd0, 11'd0);
  endtask

  task automatic sweep();
    for (int m = 1; m <= 3; m++)
      for (int v = 0; v < (1 << m); v++) send(2'(m), m, v);  // R2 R3
  endtask

  initial begin
    reset_bank_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset ready", int'(bit_ready_o), 1);
    check("R1 reset valid", int'(chip_valid_o), 0);
    check("R1 reset strobe", int'(sym_start_o), 0);
    check("R1 reset chip", int'(chip_o), 0);

    // R10 default bank, R2 every mode
    sweep();
    for (int v = 0; v < 2; v++) send(2'd0, 1, v);  // R2 mode 0 acts as 1

    // R9 loaded bank, values computed per entry
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      load_en_i = 1'b1; load_idx_i = 3'(i);
      load_code_i = 11'((i * 499 + 341) & 11'h7FF);
      @(negedge clk);
      load_en_i = 1'b0;
      exp_bank[i] = 11'((i * 499 + 341) & 11'h7FF);
    end
    sweep();

    // R8 mode change after the first bit is ignored for this packet
    mode_i = 2'd3; push_bit(1'b1);
    mode_i = 2'd1; push_bit(1'b0); push_bit(1'b1);
    check_run(exp_bank[5], 1'b0, 1'b0, 3'd0, 11'd0);
    send(2'd1, 1, 1);

    // R9 write during a run: chips in flight keep the captured code
    mode_i = 2'd2; push_bit(1'b1); push_bit(1'b0);
    check_run(exp_bank[2], 1'b0, 1'b1, 3'd2, ~exp_bank[2]);
    send(2'd2, 2, 2);

    // R7 bits offered while ready is low are not taken
    mode_i = 2'd3; push_bit(1'b0); push_bit(1'b1); push_bit(1'b1);
    check_run(exp_bank[3], 1'b1, 1'b0, 3'd0, 11'd0);
    send(2'd3, 3, 4);

    // R11 partial packet dropped at reset
    mode_i = 2'd3; push_bit(1'b1); push_bit(1'b1);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    reset_bank_model();
    send(2'd1, 1, 0);
    send(2'd3, 3, 6);

    summary();
    $finish;
  end
endmodule